// File: doc/BRIEF.md
# Elevator floor request controller

This block steers a single elevator cabin in a building whose floor count is a parameter (eight by default, floors 0 to 7). Two request sources feed it. One is the button panel inside the cabin and the other is the hall call buttons. Each source presents one floor number at a time, qualified by its own valid flag. The controller registers a floor position and outputs up, down and door-open commands. The cabin advances exactly one floor on each clock edge while it travels.

A valid cabin request always takes precedence over a hall request. The hall request waits until the cabin request has been served. When the cabin reaches the selected floor, the controller issues a one-cycle door-open pulse and then idles for one cycle. The requester must lower the matching valid flag after the door opens. Until that flag has been low for a cycle, the controller treats that request as already served, so a slow requester cannot cause a second door opening.

Top module: `lift_ctrl`

## Requirements
- R1: While rst is high and on the first cycle after it, floor_now is 0 and move_up, move_down and door_open are all 0. Reset is synchronous and active high.
- R2: When the selected target is above the current floor, each clock edge raises floor_now by exactly 1 and holds move_up at 1 until floor_now equals the target.
- R3: When the selected target is below the current floor, each clock edge lowers floor_now by exactly 1 and holds move_down at 1 until floor_now equals the target.
- R4: On the edge after floor_now reaches the target, door_open is 1 for one cycle. On that same edge move_up and move_down go to 0, and floor_now stays unchanged.
- R5: When cab_valid and hall_valid are both 1, cab_floor is the target, even when the cabin is already travelling toward hall_floor.
- R6: After a cabin request is served, a hall request that is still valid becomes the target. The cabin reverses direction if needed, stops at hall_floor and pulses door_open.
- R7: At most one of move_up, move_down and door_open is 1 in any cycle.
- R8: The cycle after a door_open pulse has all three commands at 0 and floor_now unchanged.
- R9: A served request causes no further door opening while its valid flag stays high. The request becomes eligible again only after its valid flag has been 0 for at least one clock edge.
- R10: A request whose valid flag is 0 is ignored whatever its floor value. With both valid flags at 0, the cabin stays still and all commands stay at 0.
- R11: A valid request for the current floor while idle produces door_open on the next edge, without any movement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cab_floor | input | 3 | Floor requested from inside the cabin |
| cab_valid | input | 1 | cab_floor holds a live request |
| hall_floor | input | 3 | Floor of the hall call |
| hall_valid | input | 1 | hall_floor holds a live request |
| move_up | output | 1 | Motor command: travel upward |
| move_down | output | 1 | Motor command: travel downward |
| door_open | output | 1 | One-cycle door-open command at the target floor |
| floor_now | output | 3 | Current cabin floor |

## Verification
Every piece of internal state in this block shows up at the ports within one edge. A wrong floor register appears at once on floor_now, and with a held request it also produces a direction bit that points the wrong way. A served-request mask that never clears leaves a still-valid request stranded, so the cabin simply never moves. A mask that never sets shows up as a second door_open two cycles after the first. For these reasons the directed scenarios check floor_now and all three commands on every cycle of each trip, instead of only at the endpoints.

// File: rtl/lift_pkg.sv
package lift_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DOWN = 2'd2,
    CMD_OPEN = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CAB  = 2'd1,
    SRC_HALL = 2'd2
  } src_e;
endpackage

// File: rtl/lift_req_sel.sv
module lift_req_sel
  import lift_pkg::*;
#(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] cab_floor,
  input  logic          cab_valid,
  input  logic [FW-1:0] hall_floor,
  input  logic          hall_valid,
  input  logic          serve,
  input  src_e          serve_src,
  output logic          tgt_valid,
  output logic [FW-1:0] tgt_floor,
  output src_e          tgt_src
);
  // a served request stays masked until its requester lowers valid
  logic cab_done, hall_done;
  logic cab_live, hall_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      cab_done  <= 1'b0;
      hall_done <= 1'b0;
    end else begin
      cab_done  <= cab_valid  & (cab_done  | (serve & (serve_src == SRC_CAB)));
      hall_done <= hall_valid & (hall_done | (serve & (serve_src == SRC_HALL)));
    end
  end

  assign cab_live  = cab_valid  & ~cab_done;
  assign hall_live = hall_valid & ~hall_done;

  always_comb begin
    tgt_valid = 1'b0;
    tgt_floor = '0;
    tgt_src   = SRC_NONE;
    if (cab_live) begin
      tgt_valid = 1'b1;
      tgt_floor = cab_floor;
      tgt_src   = SRC_CAB;
    end else if (hall_live) begin
      tgt_valid = 1'b1;
      tgt_floor = hall_floor;
      tgt_src   = SRC_HALL;
    end
  end

  // R9: a request already served is never served a second time
  p_no_reserve_cab_r9: assert property (@(posedge clk) disable iff (rst)
    cab_done |-> !(serve && serve_src == SRC_CAB));
  p_no_reserve_hall_r9: assert property (@(posedge clk) disable iff (rst)
    hall_done |-> !(serve && serve_src == SRC_HALL));
endmodule

// File: rtl/lift_decide.sv
module lift_decide
  import lift_pkg::*;
#(
  parameter int FW = 3
) (
  input  logic [FW-1:0] floor_cur,
  input  logic          tgt_valid,
  input  logic [FW-1:0] tgt_floor,
  input  logic          hold,
  output cmd_e          cmd
);
  always_comb begin
    if (hold || !tgt_valid)          cmd = CMD_IDLE;
    else if (tgt_floor > floor_cur)  cmd = CMD_UP;
    else if (tgt_floor < floor_cur)  cmd = CMD_DOWN;
    else                             cmd = CMD_OPEN;
  end
endmodule

// File: rtl/lift_car.sv
module lift_car
  import lift_pkg::*;
#(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  output logic [FW-1:0] floor_q,
  output logic          up_q,
  output logic          down_q,
  output logic          open_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      floor_q <= '0;
      up_q    <= 1'b0;
      down_q  <= 1'b0;
      open_q  <= 1'b0;
    end else begin
      up_q   <= (cmd == CMD_UP);
      down_q <= (cmd == CMD_DOWN);
      open_q <= (cmd == CMD_OPEN);
      case (cmd)
        CMD_UP:   floor_q <= floor_q + FW'(1);
        CMD_DOWN: floor_q <= floor_q - FW'(1);
        default:  floor_q <= floor_q;
      endcase
    end
  end

  p_one_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({up_q, down_q, open_q}) <= 1);
  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    up_q |-> floor_q == $past(floor_q) + FW'(1));
  p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
    down_q |-> floor_q == $past(floor_q) - FW'(1));
  p_open_still_r4: assert property (@(posedge clk) disable iff (rst)
    open_q |-> $stable(floor_q));
  p_gap_after_open_r8: assert property (@(posedge clk) disable iff (rst)
    open_q |=> (!open_q && !up_q && !down_q && $stable(floor_q)));
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
  import lift_pkg::*;
#(
  parameter  int FLOORS = 8,
  localparam int FW     = (FLOORS > 1) ? $clog2(FLOORS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] cab_floor,
  input  logic          cab_valid,
  input  logic [FW-1:0] hall_floor,
  input  logic          hall_valid,
  output logic          move_up,
  output logic          move_down,
  output logic          door_open,
  output logic [FW-1:0] floor_now
);
  logic          tgt_valid;
  logic [FW-1:0] tgt_floor;
  src_e          tgt_src;
  cmd_e          cmd;

  lift_req_sel #(.FW(FW)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .cab_floor (cab_floor),
    .cab_valid (cab_valid),
    .hall_floor(hall_floor),
    .hall_valid(hall_valid),
    .serve     (cmd == CMD_OPEN),
    .serve_src (tgt_src),
    .tgt_valid (tgt_valid),
    .tgt_floor (tgt_floor),
    .tgt_src   (tgt_src)
  );

  lift_decide #(.FW(FW)) u_dec (
    .floor_cur(floor_now),
    .tgt_valid(tgt_valid),
    .tgt_floor(tgt_floor),
    .hold     (door_open),
    .cmd      (cmd)
  );

  lift_car #(.FW(FW)) u_car (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .floor_q(floor_now),
    .up_q   (move_up),
    .down_q (move_down),
    .open_q (door_open)
  );

  // R10: with no valid request nothing is commanded on the next edge
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!cab_valid && !hall_valid) |=> (!move_up && !move_down && !door_open));
  // R5: with both requests live and idle, motion heads toward the cabin floor
  p_cab_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (cab_valid && hall_valid && tgt_src == SRC_CAB && !door_open
     && cab_floor > floor_now) |=> move_up);
endmodule

// File: tb/lift_ctrl_bench.sv
module lift_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cab_floor = '0;
  logic       cab_valid = 1'b0;
  logic [2:0] hall_floor = '0;
  logic       hall_valid = 1'b0;
  logic       move_up, move_down, door_open;
  logic [2:0] floor_now;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lift_ctrl u_lift_ctrl (
    .clk(clk), .rst(rst),
    .cab_floor(cab_floor), .cab_valid(cab_valid),
    .hall_floor(hall_floor), .hall_valid(hall_valid),
    .move_up(move_up), .move_down(move_down),
    .door_open(door_open), .floor_now(floor_now)
  );

  // wait one edge, then compare at the falling edge
  task automatic step(input string req, input int fl, input bit u, input bit d, input bit o);
    @(negedge clk);
    total++;
    if (floor_now !== 3'(fl) || move_up !== u || move_down !== d || door_open !== o) begin
      bad++;
      $display("FAIL %s: floor=%0d up=%0b down=%0b open=%0b expected floor=%0d up=%0b down=%0b open=%0b",
               req, floor_now, move_up, move_down, door_open, fl, u, d, o);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (floor_now !== 3'd0 || move_up || move_down || door_open) begin
      bad++;
      $display("FAIL R1: floor=%0d cmds=%0b%0b%0b expected floor=0 cmds=000",
               floor_now, move_up, move_down, door_open);
    end
    rst = 1'b0;
    step("R1", 0, 0, 0, 0);
  endtask

  task automatic t_ignore_invalid();
    cab_floor = 3'd3; hall_floor = 3'd5;
    for (int i = 0; i < 4; i++) step("R10", 0, 0, 0, 0);
  endtask

  task automatic t_same_floor();
    cab_floor = 3'd0; cab_valid = 1'b1;
    step("R11", 0, 0, 0, 1);
    cab_valid = 1'b0;
    step("R8", 0, 0, 0, 0);
  endtask

  task automatic t_priority_turnaround();
    cab_floor = 3'd6; hall_floor = 3'd1;
    cab_valid = 1'b1; hall_valid = 1'b1;
    for (int f = 1; f <= 6; f++) step("R2 R5", f, 1, 0, 0);
    step("R4", 6, 0, 0, 1);
    cab_valid = 1'b0;
    step("R8", 6, 0, 0, 0);
    for (int f = 5; f >= 1; f--) step("R3 R6", f, 0, 1, 0);
    step("R6", 1, 0, 0, 1);
    hall_valid = 1'b0;
    step("R8", 1, 0, 0, 0);
  endtask

  task automatic t_slow_release();
    cab_floor = 3'd1; cab_valid = 1'b1;
    step("R11", 1, 0, 0, 1);
    for (int i = 0; i < 3; i++) step("R9", 1, 0, 0, 0);
    cab_valid = 1'b0;
    step("R9", 1, 0, 0, 0);
    cab_valid = 1'b1;
    step("R9", 1, 0, 0, 1);
    cab_valid = 1'b0;
    step("R8", 1, 0, 0, 0);
  endtask

  task automatic t_redirect();
    hall_floor = 3'd5; hall_valid = 1'b1;
    step("R2", 2, 1, 0, 0);
    step("R2", 3, 1, 0, 0);
    cab_floor = 3'd2; cab_valid = 1'b1;
    step("R5", 2, 0, 1, 0);
    step("R4", 2, 0, 0, 1);
    cab_valid = 1'b0;
    step("R8", 2, 0, 0, 0);
    for (int f = 3; f <= 5; f++) step("R6", f, 1, 0, 0);
    step("R4", 5, 0, 0, 1);
    hall_valid = 1'b0;
    step("R8", 5, 0, 0, 0);
  endtask

  task automatic t_both_same_floor();
    cab_floor = 3'd5; hall_floor = 3'd5;
    cab_valid = 1'b1; hall_valid = 1'b1;
    step("R5", 5, 0, 0, 1);
    cab_valid = 1'b0;
    step("R8", 5, 0, 0, 0);
    step("R6", 5, 0, 0, 1);
    hall_valid = 1'b0;
    step("R8", 5, 0, 0, 0);
    step("R10", 5, 0, 0, 0);
  endtask

  task automatic t_top_and_reset();
    cab_floor = 3'd7; cab_valid = 1'b1;
    step("R2", 6, 1, 0, 0);
    step("R2", 7, 1, 0, 0);
    step("R4", 7, 0, 0, 1);
    cab_valid = 1'b0;
    step("R7", 7, 0, 0, 0);
    rst = 1'b1;
    step("R1", 0, 0, 0, 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ignore_invalid();
    t_same_floor();
    t_priority_turnaround();
    t_slow_release();
    t_redirect();
    t_both_same_floor();
    t_top_and_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule